// File: doc/BRIEF.md
# GF(2^8) Affine-Inverse Vector Unit

This block is a registered vector datapath for byte-wise finite-field work. For every byte x of a source vector it forms the multiplicative inverse of x in GF(2^8), multiplies that inverse by an 8x8 bit matrix over GF(2) and adds an 8-bit constant. The matrix comes from a second source vector, one 64-bit matrix per 64-bit group of data, and the constant comes from an 8-bit immediate that every byte shares.

A broadcast control makes every group use the matrix in group 0. A per-byte write mask picks which result bytes are written. Each masked-off byte either takes its value from a prior-destination input or is forced to zero. The active vector width (`VEC_BITS`: 128, 256 or 512) may be narrower than the port width (`MAX_BITS`), and all result bits above the active width read as zero. Each accepted operation produces its result exactly one clock after `in_vld`.

Top module: `gf_affinv_unit`

## Requirements
- R1: The inverse uses reduction polynomial 0x11B. It maps 0x00 to 0x00 and 0x01 to 0x01, and every other x to the y with x*y = 1 (for example 0x95->0x8A, 0x02->0x8D, 0x03->0xF6). With the identity matrix 0x0102040810204080 and immediate 0, each result byte equals inv(x).
- R2: Result bit i of a byte is the XOR-reduction of (matrix byte 7-i AND inv(x)) XOR `imm[i]`. Matrix byte k is bits [8k+7:8k] of the group's 64-bit matrix.
- R3: With `bcast`=0, data byte b of 64-bit group j (bits [64j+8b+7:64j+8b]) uses the matrix at `src_mat` bits [64j+63:64j].
- R4: With `bcast`=1, every group uses `src_mat` bits [63:0], and the other matrix bits have no effect.
- R5: Byte k (k = 8j+b) is written when `mask_en`=0, or when `mask_en`=1 and `wr_mask[k]`=1.
- R6: A masked-off byte reads 0x00 when `zero_mode`=1.
- R7: A masked-off byte takes byte k of `prior_dst` when `zero_mode`=0.
- R8: `dst` bits [MAX_BITS-1:VEC_BITS] are always zero.
- R9: `out_vld` equals `in_vld` of the previous clock. `dst` changes only in the clock after an accepted operation and otherwise holds.
- R10: Asynchronous active-low reset clears `out_vld` and `dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation accepted this cycle |
| src_x | input | MAX_BITS | Data bytes to transform |
| src_mat | input | MAX_BITS | One 64-bit matrix per group |
| prior_dst | input | MAX_BITS | Merge value for masked-off bytes |
| wr_mask | input | MAX_BITS/8 | Per-byte write enable |
| mask_en | input | 1 | Apply `wr_mask` |
| zero_mode | input | 1 | Masked-off bytes become zero |
| bcast | input | 1 | All groups use matrix group 0 |
| imm | input | 8 | Additive constant b |
| out_vld | output | 1 | Result valid |
| dst | output | MAX_BITS | Registered result |

## Verification
The bench builds the unit with `VEC_BITS`=256 inside 512-bit ports. Four matrix groups are then live, so broadcast can be told apart from per-group selection in three separate groups. The upper 256 port bits stay inactive, which exposes the zero-fill of R8 while random data is driven on every input bit. Thirty-two bytes per operation allow all 256 inverses to be covered in eight identity-matrix operations.

// File: rtl/gf_affinv_pkg.sv
package gf_affinv_pkg;
  localparam int          BYTE_W      = 8;
  localparam int          GROUP_BITS  = 64;
  localparam logic [8:0]  FIELD_POLY  = 9'h11B;

  // multiply two field elements, reducing by FIELD_POLY
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ FIELD_POLY[7:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // x^254 through seven squarings; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] pw;
    logic [7:0] prod;
    pw   = x;
    prod = 8'h01;
    for (int k = 1; k < 8; k++) begin
      pw   = gf_mul(pw, pw);
      prod = gf_mul(prod, pw);
    end
    return prod;
  endfunction
endpackage

// File: rtl/gf_inv_byte.sv
module gf_inv_byte
  import gf_affinv_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  always_comb begin
    y = gf_inv(x);
  end
endmodule

// File: rtl/gf_affine_byte.sv
module gf_affine_byte
  import gf_affinv_pkg::*;
(
  input  logic [BYTE_W-1:0]     x,
  input  logic [GROUP_BITS-1:0] mat,
  input  logic [BYTE_W-1:0]     cst,
  output logic [BYTE_W-1:0]     y
);
  logic [BYTE_W-1:0] inv_x;

  gf_inv_byte u_inv (
    .x (x),
    .y (inv_x)
  );

  // row for output bit i sits in matrix byte (7 - i)
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign y[i] = (^(mat[BYTE_W*(BYTE_W-1-i) +: BYTE_W] & inv_x)) ^ cst[i];
  end
endmodule

// File: rtl/gf_affinv_unit.sv
module gf_affinv_unit
  import gf_affinv_pkg::*;
#(
  parameter int VEC_BITS = 256,
  parameter int MAX_BITS = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [MAX_BITS-1:0]   src_x,
  input  logic [MAX_BITS-1:0]   src_mat,
  input  logic [MAX_BITS-1:0]   prior_dst,
  input  logic [MAX_BITS/8-1:0] wr_mask,
  input  logic                  mask_en,
  input  logic                  zero_mode,
  input  logic                  bcast,
  input  logic [7:0]            imm,
  output logic                  out_vld,
  output logic [MAX_BITS-1:0]   dst
);
  localparam int NGROUPS   = VEC_BITS / GROUP_BITS;
  localparam int GRP_BYTES = GROUP_BITS / BYTE_W;

  logic [MAX_BITS-1:0] res_c;
  logic [MAX_BITS-1:0] dst_d;
  logic                vld_d;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    logic [GROUP_BITS-1:0] mat_sel;
    assign mat_sel = bcast ? src_mat[GROUP_BITS-1:0]
                           : src_mat[g*GROUP_BITS +: GROUP_BITS];

    for (genvar b = 0; b < GRP_BYTES; b++) begin : g_byte
      localparam int K = g*GRP_BYTES + b;
      logic [BYTE_W-1:0] aff;
      logic              wen;

      gf_affine_byte u_aff (
        .x   (src_x[K*BYTE_W +: BYTE_W]),
        .mat (mat_sel),
        .cst (imm),
        .y   (aff)
      );

      assign wen = !mask_en || wr_mask[K];
      assign res_c[K*BYTE_W +: BYTE_W] =
        wen       ? aff :
        zero_mode ? '0  : prior_dst[K*BYTE_W +: BYTE_W];
    end
  end

  if (VEC_BITS < MAX_BITS) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^{src_x[MAX_BITS-1:VEC_BITS], src_mat[MAX_BITS-1:VEC_BITS],
                         prior_dst[MAX_BITS-1:VEC_BITS], wr_mask[MAX_BITS/8-1:VEC_BITS/8]};
    assign res_c[MAX_BITS-1:VEC_BITS] = '0;
  end

  // next state: load on accepted operation, hold otherwise
  always_comb begin
    vld_d = in_vld;
    dst_d = in_vld ? res_c : dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      dst     <= '0;
    end else begin
      out_vld <= vld_d;
      dst     <= dst_d;
    end
  end
endmodule

// File: rtl/gf_affinv_unit_chk.sv
module gf_affinv_unit_chk #(
  parameter int VEC_BITS = 256,
  parameter int MAX_BITS = 512
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_vld,
  input logic [MAX_BITS-1:0]   prior_dst,
  input logic [MAX_BITS/8-1:0] wr_mask,
  input logic                  mask_en,
  input logic                  zero_mode,
  input logic                  out_vld,
  input logic [MAX_BITS-1:0]   dst
);
  localparam int NB = VEC_BITS / 8;

  assert_lat_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld) |-> $stable(dst));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_vld && dst == '0));

  if (VEC_BITS < MAX_BITS) begin : g_hi
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dst[MAX_BITS-1:VEC_BITS] == '0);
  end

  for (genvar k = 0; k < NB; k++) begin : g_b
    assert_zeroed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld && mask_en && zero_mode && !wr_mask[k]) |-> dst[k*8 +: 8] == 8'h00);
    assert_merged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld && mask_en && !zero_mode && !wr_mask[k])
        |-> dst[k*8 +: 8] == $past(prior_dst[k*8 +: 8]));
  end
endmodule

bind gf_affinv_unit gf_affinv_unit_chk #(.VEC_BITS(VEC_BITS), .MAX_BITS(MAX_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .prior_dst (prior_dst),
  .wr_mask   (wr_mask),
  .mask_en   (mask_en),
  .zero_mode (zero_mode),
  .out_vld   (out_vld),
  .dst       (dst)
);

// File: tb/test_gf_affinv_unit.sv
module test_gf_affinv_unit;
  localparam int VB = 256;
  localparam int MB = 512;
  localparam logic [63:0] IDENT = 64'h0102040810204080;

  logic clk = 1'b0;
  logic rst_n;
  logic in_vld, mask_en, zero_mode, bcast;
  logic [MB-1:0] src_x, src_mat, prior_dst, dst;
  logic [MB/8-1:0] wr_mask;
  logic [7:0] imm;
  logic out_vld;

  int n_chk = 0;
  int n_bad = 0;
  logic [MB-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  gf_affinv_unit #(.VEC_BITS(VB), .MAX_BITS(MB)) i_gf_affinv_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_x(src_x), .src_mat(src_mat),
    .prior_dst(prior_dst), .wr_mask(wr_mask), .mask_en(mask_en), .zero_mode(zero_mode),
    .bcast(bcast), .imm(imm), .out_vld(out_vld), .dst(dst)
  );

  // shift-and-add product, reduction by 0x11B
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h11B << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] x);
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [MB-1:0] model(input logic [MB-1:0] x, input logic [MB-1:0] m,
      input logic [MB-1:0] pr, input logic [MB/8-1:0] mk, input logic me, input logic zm,
      input logic bc, input logic [7:0] c);
    logic [MB-1:0] r = '0;
    for (int k = 0; k < VB/8; k++) begin
      logic [63:0] mt = bc ? m[63:0] : m[(k/8)*64 +: 64];
      logic [7:0] iv = m_inv(x[k*8 +: 8]);
      logic [7:0] o;
      for (int i = 0; i < 8; i++) o[i] = (^(mt[(7-i)*8 +: 8] & iv)) ^ c[i];
      if (!me || mk[k]) r[k*8 +: 8] = o;
      else if (zm) r[k*8 +: 8] = 8'h00;
      else r[k*8 +: 8] = pr[k*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [MB-1:0] rnd_vec();
    logic [MB-1:0] v;
    for (int i = 0; i < MB/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [MB-1:0] act, input logic [MB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [MB-1:0] x, input logic [MB-1:0] m,
      input logic [MB-1:0] pr, input logic [MB/8-1:0] mk, input logic me, input logic zm,
      input logic bc, input logic [7:0] c);
    src_x = x; src_mat = m; prior_dst = pr; wr_mask = mk;
    mask_en = me; zero_mode = zm; bcast = bc; imm = c; in_vld = 1'b1;
    exp_q.push_back(model(x, m, pr, mk, me, zm, bc, c));
    tag_q.push_back(req);
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // monitor: result appears one clock after acceptance
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (exp_q.size() == 0) check("R9 unexpected out_vld", {MB{1'b1}}, '0);
      else check(tag_q.pop_front(), dst, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [MB-1:0] idm, x, held;
    rst_n = 1'b0; in_vld = 1'b0; src_x = '0; src_mat = '0; prior_dst = '0;
    wr_mask = '0; mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0; imm = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 reset dst", dst, '0);
    check("R10 reset out_vld", {511'b0, out_vld}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    idm = '0;
    for (int g = 0; g < MB/64; g++) idm[g*64 +: 64] = IDENT;

    // R1: known inverse values through the identity matrix
    x = '0;
    x[7:0] = 8'h95; x[15:8] = 8'h02; x[23:16] = 8'h03; x[31:24] = 8'h00; x[39:32] = 8'h01;
    drive("R1 examples", x, idm, '0, '0, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    n_chk++;
    if (dst[39:0] !== 40'h01_00_F6_8D_8A) begin
      n_bad++;
      $display("FAIL R1 act=%h exp=0100f68d8a", dst[39:0]);
    end

    // R1: all 256 inputs, x*inv(x)=1 via model, plus direct product check
    for (int t = 0; t < 8; t++) begin
      x = '0;
      for (int k = 0; k < 32; k++) x[k*8 +: 8] = 8'(t*32 + k);
      drive("R1 sweep", x, idm, '0, '0, 1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      for (int k = 0; k < 32; k++) begin
        logic [7:0] xv = 8'(t*32 + k);
        if (xv != 0) begin
          n_chk++;
          if (m_mul(xv, dst[k*8 +: 8]) != 8'h01) begin
            n_bad++;
            $display("FAIL R1 x=%h act=%h exp=product 01", xv, dst[k*8 +: 8]);
          end
        end
      end
    end

    // R2 immediate and random matrices; R3 per-group matrices
    for (int t = 0; t < 6; t++)
      drive("R2 R3 random", rnd_vec(), rnd_vec(), rnd_vec(), '0, 1'b0, 1'b0, 1'b0, 8'($urandom));
    // R4 broadcast with random upper matrices
    for (int t = 0; t < 6; t++)
      drive("R4 broadcast", rnd_vec(), rnd_vec(), rnd_vec(), '0, 1'b0, 1'b0, 1'b1, 8'($urandom));
    // R5 R6 R7 masking (R8 covered by model upper zeros)
    for (int t = 0; t < 8; t++)
      drive("R5 R6 mask zero", rnd_vec(), rnd_vec(), rnd_vec(), {$urandom, $urandom},
            1'b1, 1'b1, t[0], 8'($urandom));
    for (int t = 0; t < 8; t++)
      drive("R5 R7 mask merge R8", rnd_vec(), rnd_vec(), rnd_vec(), {$urandom, $urandom},
            1'b1, 1'b0, t[0], 8'($urandom));
    drive("R5 mask_en off", rnd_vec(), rnd_vec(), rnd_vec(), '0, 1'b0, 1'b1, 1'b0, 8'h63);
    @(negedge clk);

    // R9 hold: inputs change without in_vld, dst must stay
    held = dst;
    src_x = rnd_vec(); src_mat = rnd_vec(); imm = 8'hA5;
    repeat (3) @(negedge clk);
    check("R9 hold", dst, held);
    check("R9 idle out_vld", {511'b0, out_vld}, '0);

    repeat (2) @(negedge clk);
    check("R9 queue drained", {480'b0, 32'(exp_q.size())}, '0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule